// File: doc/BRIEF.md
# Interleaved Multi-Slot Pipelined Accumulator

This block adds up a stream of words that arrive with a valid tag, using an adder that takes `LAT` clock cycles to produce each result. Feeding every term back into one running total would have to wait for the previous sum to leave the adder. To avoid that, the block keeps `LAT` separate partial sums in a small slot bank. A slot pointer advances by one on every accumulate cycle, and each valid term is added into the slot the pointer selects. A slot's previous result therefore leaves the adder in the same cycle that the slot is selected again.

Cycles whose valid tag is low are simply not issued. No global stall enable exists. A bubble still moves the pointer on, so it changes which slot receives the later terms. With integer data the final total is unaffected.

A frame of terms ends with a term that carries the last flag. The block then waits until the adder pipeline is empty. It reduces the slots pairwise, in halving rounds that reuse the same adder, and presents the total together with a one-cycle done strobe. Every new frame starts from cleared partial sums. One instance handles one vector component, so three instances side by side produce the three components of an acceleration.

Top module: `slot_accum`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `sum_done` is 0 and `sum_out` is 0.
- R2: The `sum_out` reported with `sum_done` equals the sum, modulo 2^W, of every `in_data` that was sampled with `in_vld` = 1 from the start of the frame up to and including the accepted last term. Cycles with `in_vld` = 0 contribute nothing, wherever they fall.
- R3: The partial sums start from zero in every frame, so a frame's total never includes terms from an earlier frame.
- R4: `in_last` takes effect only in a cycle where `in_vld` = 1. `in_last` = 1 with `in_vld` = 0 neither ends the frame nor adds a term.
- R5: `sum_done` is a single-cycle pulse. It never rises before the last term of the frame is accepted. It rises no more than B cycles after that term, where B = (LAT+3) + Σ(ceil(n/2) + LAT + 3) + 3 and n runs from L = LAT through the repeated ceil(n/2) halvings while n > 1 (B = 90 for LAT = 12). When the pulse rises the adder pipeline is empty.
- R6: `sum_out` changes only in a cycle where `sum_done` is high, and it holds its value until the next pulse.
- R7: Terms presented after the accepted last term and before the `sum_done` cycle are discarded. They enter neither the current total nor the next frame. This holds even when they carry `in_last`.
- R8: Frames of any length are summed correctly, including a single term, fewer terms than L, exactly L terms and several multiples of L.
- R9: The first term of the next frame may be presented in the same cycle that `sum_done` is high.
- R10: During accumulation, each term sampled with `in_vld` = 1 is in the adder pipeline on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Term on `in_data` is valid this cycle |
| in_data | input | W | Term to accumulate (two's complement, wraps modulo 2^W) |
| in_last | input | 1 | Marks the final term of the frame when `in_vld` is high |
| sum_out | output | W | Registered frame total |
| sum_done | output | 1 | One-cycle strobe: `sum_out` holds a new total |

## Verification
A term is sampled on the rising edge that follows the falling edge where the bench drives it. The bench therefore drives on falling edges and reads outputs on falling edges, so every value it reads has settled a half period earlier. After it drives the last term of a frame, the bench counts falling edges until `sum_done` is seen. It flags a strobe that arrives before the last term or more than B cycles after it, and compares `sum_out` with its own modulo-2^W sum in that same cycle. One falling edge later it expects the strobe to have dropped, and after an idle gap it expects `sum_out` to be unchanged. When the next frame starts in the strobe cycle itself, the following total shows whether that first term was counted exactly once.

// File: rtl/slot_accum_pkg.sv
package slot_accum_pkg;

  // Controller phases of the accumulator.
  typedef enum logic [1:0] {
    PH_ACCUM = 2'd0,  // taking terms from the input stream
    PH_DRAIN = 2'd1,  // waiting for in-flight additions to land
    PH_RISSUE = 2'd2, // issuing one pairwise reduction round
    PH_RWAIT = 2'd3   // waiting for that round to land
  } phase_t;

  // Number of values left after one pairwise round.
  function automatic int unsigned halve_up(input int unsigned n);
    return (n + 1) / 2;
  endfunction

endpackage

// File: rtl/slot_accum_adder.sv
// Stand-in for a floating-point adder: an integer adder followed by a
// delay line, with a valid tag and a slot tag carried alongside the data.
module slot_accum_adder #(
  parameter int W   = 32,
  parameter int LAT = 12,
  parameter int TW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_vld,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [TW-1:0] op_tag,
  output logic          res_vld,
  output logic [W-1:0]  res_sum,
  output logic [TW-1:0] res_tag,
  output logic          busy
);

  logic [LAT-1:0] vld_q;
  logic [W-1:0]   sum_q [LAT];
  logic [TW-1:0]  tag_q [LAT];

  // Validity is the only reset state; data stages are free-running.
  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[LAT-2:0], op_vld};
  end

  always_ff @(posedge clk) begin
    sum_q[0] <= op_a + op_b;
    tag_q[0] <= op_tag;
    for (int s = 1; s < LAT; s++) begin
      sum_q[s] <= sum_q[s-1];
      tag_q[s] <= tag_q[s-1];
    end
  end

  assign res_vld = vld_q[LAT-1];
  assign res_sum = sum_q[LAT-1];
  assign res_tag = tag_q[LAT-1];
  assign busy    = |vld_q;

endmodule

// File: rtl/slot_accum_bank.sv
// Partial-sum storage: one write port, two asynchronous read ports, and a
// per-slot "fresh" bit so a whole frame can be cleared in one cycle.
module slot_accum_bank #(
  parameter int W  = 32,
  parameter int L  = 12,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_all,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_slot,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_a_slot,
  output logic [W-1:0]  rd_a_data,
  input  logic [AW-1:0] rd_b_slot,
  output logic [W-1:0]  rd_b_data,
  output logic [L-1:0]  fresh_o
);

  logic [W-1:0] mem [L];
  logic [L-1:0] fresh;
  logic [L-1:0] hit;

  // Storage without reset so it can map onto distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot] <= wr_data;
  end

  for (genvar i = 0; i < L; i++) begin : g_hit
    assign hit[i] = wr_en && (wr_slot == AW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) fresh <= '1;
    else                fresh <= fresh & ~hit;
  end

  assign rd_a_data = fresh[rd_a_slot] ? '0 : mem[rd_a_slot];
  assign rd_b_data = fresh[rd_b_slot] ? '0 : mem[rd_b_slot];
  assign fresh_o   = fresh;

endmodule

// File: rtl/slot_accum.sv
module slot_accum #(
  parameter int W   = 32,
  parameter int LAT = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic [W-1:0] sum_out,
  output logic         sum_done
);
  import slot_accum_pkg::*;

  localparam int L  = LAT;
  localparam int AW = (L > 2) ? $clog2(L) : 1;
  localparam int CW = $clog2(L + 1);

  phase_t        phase;
  logic [AW-1:0] ptr;
  logic [AW-1:0] k;
  logic [CW-1:0] n_cur;
  logic [CW-1:0] n_half;

  logic          op_vld;
  logic [W-1:0]  op_a, op_b;
  logic [AW-1:0] op_tag;
  logic          res_vld;
  logic [W-1:0]  res_sum;
  logic [AW-1:0] res_tag;
  logic          pipe_busy;

  logic [AW-1:0] rd_a_slot, rd_b_slot;
  logic [W-1:0]  rd_a_data, rd_b_data;
  logic [L-1:0]  fresh_vec;
  logic          finish;
  logic          acc_phase;
  logic [AW:0]   two_k;
  logic [AW:0]   b_idx;
  logic          has_b;

  assign acc_phase = (phase == PH_ACCUM);
  assign n_half    = CW'(halve_up(int'(n_cur)));
  assign two_k     = {k, 1'b0};
  assign b_idx     = two_k + 1'b1;
  assign has_b     = (int'(b_idx) < int'(n_cur));
  assign finish    = (phase == PH_RWAIT) && !pipe_busy && (n_half == CW'(1));

  // Operand selection: stream terms during accumulation, slot pairs during
  // reduction. A result leaving the adder for the selected slot bypasses
  // the bank, since it lands in the very cycle the slot comes round again.
  always_comb begin
    op_vld    = 1'b0;
    op_a      = in_data;
    op_b      = rd_a_data;
    op_tag    = ptr;
    rd_a_slot = '0;
    rd_b_slot = '0;
    unique case (phase)
      PH_ACCUM: begin
        rd_a_slot = ptr;
        op_vld    = in_vld;
        op_a      = in_data;
        op_b      = (res_vld && res_tag == ptr) ? res_sum : rd_a_data;
        op_tag    = ptr;
      end
      PH_RISSUE: begin
        rd_a_slot = two_k[AW-1:0];
        rd_b_slot = b_idx[AW-1:0];
        op_vld    = 1'b1;
        op_a      = rd_a_data;
        op_b      = has_b ? rd_b_data : '0;
        op_tag    = k;
      end
      default: begin
        rd_a_slot = '0;
      end
    endcase
  end

  slot_accum_adder #(.W(W), .LAT(LAT), .TW(AW)) u_add (
    .clk     (clk),
    .rst     (rst),
    .op_vld  (op_vld),
    .op_a    (op_a),
    .op_b    (op_b),
    .op_tag  (op_tag),
    .res_vld (res_vld),
    .res_sum (res_sum),
    .res_tag (res_tag),
    .busy    (pipe_busy)
  );

  slot_accum_bank #(.W(W), .L(L), .AW(AW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .clr_all   (finish),
    .wr_en     (res_vld),
    .wr_slot   (res_tag),
    .wr_data   (res_sum),
    .rd_a_slot (rd_a_slot),
    .rd_a_data (rd_a_data),
    .rd_b_slot (rd_b_slot),
    .rd_b_data (rd_b_data),
    .fresh_o   (fresh_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_ACCUM;
      ptr      <= '0;
      k        <= '0;
      n_cur    <= CW'(L);
      sum_out  <= '0;
      sum_done <= 1'b0;
    end else begin
      sum_done <= 1'b0;
      unique case (phase)
        PH_ACCUM: begin
          ptr <= (ptr == AW'(L - 1)) ? '0 : ptr + 1'b1;
          if (in_vld && in_last) phase <= PH_DRAIN;
        end
        PH_DRAIN: begin
          if (!pipe_busy) begin
            phase <= PH_RISSUE;
            k     <= '0;
            n_cur <= CW'(L);
          end
        end
        PH_RISSUE: begin
          if (CW'(k) == n_half - 1'b1) phase <= PH_RWAIT;
          else                         k     <= k + 1'b1;
        end
        PH_RWAIT: begin
          if (!pipe_busy) begin
            if (n_half == CW'(1)) begin
              sum_out  <= rd_a_data;
              sum_done <= 1'b1;
              phase    <= PH_ACCUM;
              ptr      <= '0;
            end else begin
              n_cur <= n_half;
              k     <= '0;
              phase <= PH_RISSUE;
            end
          end
        end
        default: phase <= PH_ACCUM;
      endcase
    end
  end

  initial begin
    if (LAT < 2) $error("slot_accum: LAT must be at least 2");
  end

endmodule

// File: rtl/slot_accum_chk.sv
module slot_accum_chk #(
  parameter int W = 32,
  parameter int L = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         in_vld,
  input logic [W-1:0] sum_out,
  input logic         sum_done,
  input logic         pipe_busy,
  input logic [L-1:0] fresh,
  input logic         acc_phase
);

  // R1: outputs are quiet right after a reset edge.
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!sum_done && sum_out == '0));

  // R5: the done strobe lasts one cycle.
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    sum_done |=> !sum_done);

  // R5: nothing is left in the adder when the total is presented.
  a_r5_drained_at_done: assert property (@(posedge clk) disable iff (rst)
    sum_done |-> !pipe_busy);

  // R3: every slot reads as zero when the next frame may begin.
  a_r3_cleared_on_done: assert property (@(posedge clk) disable iff (rst)
    sum_done |-> (fresh == '1));

  // R6: the total only moves together with the strobe.
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !sum_done |-> $stable(sum_out));

  // R10: an accepted term is in the adder one cycle later.
  a_r10_term_issued: assert property (@(posedge clk) disable iff (rst)
    (acc_phase && in_vld) |=> pipe_busy);

endmodule

bind slot_accum slot_accum_chk #(.W(W), .L(LAT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_vld    (in_vld),
  .sum_out   (sum_out),
  .sum_done  (sum_done),
  .pipe_busy (pipe_busy),
  .fresh     (fresh_vec),
  .acc_phase (acc_phase)
);

// File: tb/sim_slot_accum.sv
module sim_slot_accum;
  localparam int W   = 32;
  localparam int LAT = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_last = 1'b0;
  logic [W-1:0] sum_out;
  logic         sum_done;

  int nchk  = 0;
  int nfail = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  slot_accum #(.W(W), .LAT(LAT)) u0 (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_data  (in_data),
    .in_last  (in_last),
    .sum_out  (sum_out),
    .sum_done (sum_done)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int bound_cycles();
    int n = LAT;
    int b = LAT + 3;
    while (n > 1) begin
      b += (n + 1) / 2 + LAT + 3;
      n = (n + 1) / 2;
    end
    return b + 3;
  endfunction

  // One frame: nterms valid terms, bub_pct percent bubbles, optional
  // lone last flags on bubbles (R4), junk while the block reduces (R7),
  // imm = first term driven in the previous frame's done cycle (R9),
  // gap = idle cycles after done for hold checks (R5, R6).
  task automatic run_frame(input int nterms, input int bub_pct,
                           input bit fake_last, input bit junk,
                           input bit imm, input bit ones,
                           input int gap, input string tag);
    logic [W-1:0] expect_sum = '0;
    logic [W-1:0] d;
    int sent = 0;
    int early = 0;
    int cyc = 0;
    bit first = 1'b1;
    while (sent < nterms) begin
      if (!(first && imm)) @(negedge clk);
      if (!first && sum_done) early++;
      first = 1'b0;
      if ($urandom_range(99) < bub_pct) begin
        in_vld  = 1'b0;
        in_data = $urandom;
        in_last = fake_last ? 1'($urandom_range(1)) : 1'b0;
      end else begin
        d = ones ? '1 : W'($urandom);
        in_vld  = 1'b1;
        in_data = d;
        in_last = (sent == nterms - 1);
        expect_sum += d;
        sent++;
      end
    end
    forever begin
      @(negedge clk);
      if (sum_done) break;
      cyc++;
      if (cyc > bound_cycles() + 20) break;
      if (junk) begin
        in_vld  = 1'b1;
        in_data = $urandom;
        in_last = 1'($urandom_range(1));
      end else begin
        in_vld  = 1'b0;
        in_last = 1'b0;
      end
    end
    in_vld  = 1'b0;
    in_last = 1'b0;
    chk(early == 0, {"R5 no early strobe ", tag}, W'(early), '0);
    chk(sum_done && cyc < bound_cycles(), {"R5 strobe within bound ", tag},
        W'(cyc), W'(bound_cycles()));
    chk(sum_out == expect_sum, {"R2 R10 total ", tag}, sum_out, expect_sum);
    if (gap > 0) begin
      @(negedge clk);
      chk(!sum_done, {"R5 single-cycle strobe ", tag}, W'(sum_done), '0);
      repeat (gap) @(negedge clk);
      chk(sum_out == expect_sum && !sum_done, {"R6 hold ", tag},
          sum_out, expect_sum);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sum_done == 1'b0 && sum_out == '0, "R1 during reset", sum_out, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(sum_done == 1'b0 && sum_out == '0, "R1 after reset", sum_out, '0);

    run_frame(3 * LAT, 0,  0, 0, 0, 0, 3, "R8 dense 3L");
    run_frame(1,       0,  0, 0, 0, 0, 2, "R8 single term");
    run_frame(5,       30, 0, 0, 0, 0, 2, "R8 short frame");
    run_frame(LAT,     0,  0, 0, 0, 0, 2, "R8 exactly L");
    run_frame(LAT + 1, 50, 0, 0, 0, 0, 2, "R2 half bubbles");
    run_frame(40,      80, 0, 0, 0, 0, 2, "R2 sparse");
    run_frame(30,      40, 1, 0, 0, 0, 2, "R4 lone last flags");
    run_frame(25,      20, 0, 0, 0, 1, 2, "R2 all-ones wrap");
    run_frame(17,      25, 0, 1, 0, 0, 0, "R7 junk while reducing");
    run_frame(9,       10, 1, 1, 1, 0, 0, "R9 start in done cycle");
    run_frame(2,       0,  0, 0, 1, 0, 2, "R3 R9 back to back");
    for (int f = 0; f < 10; f++) begin
      run_frame(1 + (f * 7) % 50, (f * 13) % 90, f[0], f[1], 0, 0, 1,
                "R2 R3 sweep");
    end

    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule